// File: doc/BRIEF.md
# SPI Buffer Service Request Generator

This block sits beside the transmit and receive FIFOs of a serial peripheral interface controller. It raises the two service-request lines that ask software or a DMA engine to refill the transmit FIFO or drain the receive FIFO. It reads the FIFO occupancy counts, the FIFO depth and a flag that shows the shift register still holds a word. Each direction has its own 2-bit selector, which picks one of four trigger conditions.

The block also guards the receive FIFO write port. A word arriving while the receive FIFO is full is an overflow. That word is never written, so the stored contents stay intact. The overflow-ignore bit chooses the policy. With the bit clear, the overflow is a critical error and a halt request is raised. With the bit set, the word is dropped and operation continues. Either way a sticky overflow flag records the event. The selectors and the ignore bit are held in configuration registers that only accept a write while the block is disabled.

Top module: `spi_svc_req`

## Requirements
- R1: With transmit selector 2'b11, `tx_req` is high one clock after the transmit count is below the FIFO depth.
- R2: With transmit selector 2'b10, `tx_req` is high one clock after the free space (depth minus count) doubled is at least the depth.
- R3: With transmit selector 2'b01, `tx_req` is high one clock after the transmit count is zero.
- R4: With transmit selector 2'b00, `tx_req` is high one clock after the transmit count is zero while `shift_busy` is low.
- R5: `rx_req` follows the receive selector one clock later: 2'b11 full (count equals depth), 2'b10 count doubled at least the depth, 2'b01 count non-zero, 2'b00 count zero.
- R6: When `enable` is low at a clock edge, `tx_req`, `rx_req` and `halt_req` are low after that edge, and `rx_fifo_we` is low.
- R7: `cfg_wr` loads `tx_sel_in`, `rx_sel_in` and `ovf_ign_in` only while `enable` is low. A write while enabled has no effect. All three reset to zero.
- R8: `rx_fifo_we` is high in the same cycle as `rx_word_valid` when enabled, not halted and the receive count is below the depth. It is never high while the receive FIFO is full.
- R9: A word arriving while enabled, not halted and with the receive FIFO full sets `ovf_flag` at the next edge. The flag stays set until `ovf_clear` is seen at an edge with no new overflow. A new overflow wins over the clear.
- R10: With the ignore bit clear, an overflow sets `halt_req`. While `halt_req` is high, no word is written and no further overflow is detected. `halt_req` clears at the first edge with `enable` low.
- R11: With the ignore bit set, an overflow never raises `halt_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Block enable |
| cfg_wr | input | 1 | Configuration write strobe |
| tx_sel_in | input | 2 | Transmit trigger selector to load |
| rx_sel_in | input | 2 | Receive trigger selector to load |
| ovf_ign_in | input | 1 | Overflow-ignore bit to load |
| tx_count | input | CNT_W | Transmit FIFO occupancy |
| rx_count | input | CNT_W | Receive FIFO occupancy |
| fifo_depth | input | CNT_W | FIFO depth in words |
| shift_busy | input | 1 | Shift register holds a word |
| rx_word_valid | input | 1 | Received word strobe |
| ovf_clear | input | 1 | Write-one-to-clear for the overflow flag |
| tx_req | output | 1 | Transmit service request |
| rx_req | output | 1 | Receive service request |
| ovf_flag | output | 1 | Sticky overflow flag |
| halt_req | output | 1 | Critical-error halt request |
| rx_fifo_we | output | 1 | Receive FIFO write enable |

## Verification
The bench builds the block with CNT_W of 4 and drives the depth input at 8 and then at 5. The even depth lets both half thresholds be hit exactly. The odd depth checks the rounding of "at least half", where 3 free or 3 used words out of 5 count and 2 do not. The small count width keeps full and empty FIFOs frequent under random counts, so overflows, halts, clears that race new overflows, and writes attempted while enabled all occur many times.

// File: rtl/spi_svc_req.sv
module spi_svc_req #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             cfg_wr,
  input  logic [1:0]       tx_sel_in,
  input  logic [1:0]       rx_sel_in,
  input  logic             ovf_ign_in,
  input  logic [CNT_W-1:0] tx_count,
  input  logic [CNT_W-1:0] rx_count,
  input  logic [CNT_W-1:0] fifo_depth,
  input  logic             shift_busy,
  input  logic             rx_word_valid,
  input  logic             ovf_clear,
  output logic             tx_req,
  output logic             rx_req,
  output logic             ovf_flag,
  output logic             halt_req,
  output logic             rx_fifo_we
);
  localparam int W = CNT_W + 2;

  logic [1:0] tx_sel_q, rx_sel_q;
  logic       ign_q;
  logic [W-1:0] depth_x, tx_x, rx_x, tx_free;
  logic tx_cond, rx_cond, rx_full, accept, ovf_evt;

  assign depth_x = {2'b00, fifo_depth};
  assign tx_x    = {2'b00, tx_count};
  assign rx_x    = {2'b00, rx_count};
  assign tx_free = depth_x - tx_x;
  assign rx_full = rx_x >= depth_x;

  always_comb begin
    case (tx_sel_q)
      2'b11:   tx_cond = tx_x < depth_x;
      2'b10:   tx_cond = (tx_free << 1) >= depth_x;
      2'b01:   tx_cond = tx_x == '0;
      default: tx_cond = (tx_x == '0) && !shift_busy;
    endcase
    case (rx_sel_q)
      2'b11:   rx_cond = rx_full;
      2'b10:   rx_cond = (rx_x << 1) >= depth_x;
      2'b01:   rx_cond = rx_x != '0;
      default: rx_cond = rx_x == '0;
    endcase
  end

  assign accept     = enable && !halt_req && rx_word_valid;
  assign ovf_evt    = accept && rx_full;
  assign rx_fifo_we = accept && !rx_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sel_q <= 2'b00;
      rx_sel_q <= 2'b00;
      ign_q    <= 1'b0;
    end else if (cfg_wr && !enable) begin
      tx_sel_q <= tx_sel_in;
      rx_sel_q <= rx_sel_in;
      ign_q    <= ovf_ign_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_req   <= 1'b0;
      rx_req   <= 1'b0;
      ovf_flag <= 1'b0;
      halt_req <= 1'b0;
    end else begin
      tx_req   <= enable && tx_cond;
      rx_req   <= enable && rx_cond;
      ovf_flag <= ovf_evt || (ovf_flag && !ovf_clear);
      halt_req <= enable && (halt_req || (ovf_evt && !ign_q));
    end
  end
endmodule

module spi_svc_req_chk #(
  parameter int CNT_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             enable,
  input logic [CNT_W-1:0] rx_count,
  input logic [CNT_W-1:0] fifo_depth,
  input logic             ovf_clear,
  input logic             tx_req,
  input logic             rx_req,
  input logic             ovf_flag,
  input logic             halt_req,
  input logic             rx_fifo_we,
  input logic [1:0]       tx_sel_q,
  input logic [1:0]       rx_sel_q,
  input logic             ign_q
);
  // R8
  no_full_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_fifo_we |-> rx_count < fifo_depth);
  // R9
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_flag && !ovf_clear |=> ovf_flag);
  // R6
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !tx_req && !rx_req && !halt_req);
  // R7
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    enable && $past(enable) |-> $stable(tx_sel_q) && $stable(rx_sel_q) && $stable(ign_q));
  // R11
  ign_no_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ign_q && !halt_req |=> !halt_req);
  // R10
  halt_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halt_req |-> !rx_fifo_we);
endmodule

bind spi_svc_req spi_svc_req_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .rx_count(rx_count),
  .fifo_depth(fifo_depth), .ovf_clear(ovf_clear), .tx_req(tx_req),
  .rx_req(rx_req), .ovf_flag(ovf_flag), .halt_req(halt_req),
  .rx_fifo_we(rx_fifo_we), .tx_sel_q(tx_sel_q), .rx_sel_q(rx_sel_q),
  .ign_q(ign_q)
);

// File: tb/test_spi_svc_req.sv
module test_spi_svc_req;
  localparam int CW = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic enable = 0, cfg_wr = 0, ovf_ign_in = 0, shift_busy = 0, rx_word_valid = 0, ovf_clear = 0;
  logic [1:0] tx_sel_in = 0, rx_sel_in = 0;
  logic [CW-1:0] tx_count = 0, rx_count = 0, fifo_depth = 8;
  logic tx_req, rx_req, ovf_flag, halt_req, rx_fifo_we;

  int checks = 0, errors = 0;
  int m_txs = 0, m_rxs = 0, m_ign = 0;
  int m_tx = 0, m_rx = 0, m_ovf = 0, m_halt = 0;

  always #10 clk = ~clk;

  spi_svc_req #(.CNT_W(CW)) i_spi_svc_req (
    .clk(clk), .rst_n(rst_n), .enable(enable), .cfg_wr(cfg_wr),
    .tx_sel_in(tx_sel_in), .rx_sel_in(rx_sel_in), .ovf_ign_in(ovf_ign_in),
    .tx_count(tx_count), .rx_count(rx_count), .fifo_depth(fifo_depth),
    .shift_busy(shift_busy), .rx_word_valid(rx_word_valid), .ovf_clear(ovf_clear),
    .tx_req(tx_req), .rx_req(rx_req), .ovf_flag(ovf_flag),
    .halt_req(halt_req), .rx_fifo_we(rx_fifo_we)
  );

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: %s got %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic string tx_tag(input int s);
    case (s)
      3: return "R1";
      2: return "R2";
      1: return "R3";
      default: return "R4";
    endcase
  endfunction

  // One clock: check the write enable, advance the model, check registered outputs.
  task automatic step();
    int d, t, r, nt, nr, acc, full;
    #1;
    d = fifo_depth; t = tx_count; r = rx_count;
    full = (r >= d);
    acc = enable && !m_halt && rx_word_valid;
    check(m_halt ? "R10" : "R8", "rx_fifo_we", rx_fifo_we, acc && !full);
    case (m_txs)
      3: nt = t < d;
      2: nt = 2 * (d - t) >= d;
      1: nt = t == 0;
      default: nt = (t == 0) && !shift_busy;
    endcase
    case (m_rxs)
      3: nr = full;
      2: nr = 2 * r >= d;
      1: nr = r != 0;
      default: nr = r == 0;
    endcase
    m_tx = enable && nt;
    m_rx = enable && nr;
    m_halt = enable && (m_halt || (acc && full && !m_ign));
    m_ovf = (acc && full) || (m_ovf && !ovf_clear);
    if (cfg_wr && !enable) begin
      m_txs = tx_sel_in; m_rxs = rx_sel_in; m_ign = ovf_ign_in;
    end
    @(negedge clk);
    check(enable ? tx_tag(m_txs) : "R6", "tx_req", tx_req, m_tx);
    check(enable ? "R5" : "R6", "rx_req", rx_req, m_rx);
    check("R9", "ovf_flag", ovf_flag, m_ovf);
    check(m_ign ? "R11" : "R10", "halt_req", halt_req, m_halt);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    check("R6", "reset tx_req", tx_req, 0);
    check("R9", "reset ovf_flag", ovf_flag, 0);
    rst_n = 1'b1;
    // R7: select empty-trigger while disabled, then try to change it while enabled
    cfg_wr = 1; tx_sel_in = 2'b01; step();
    cfg_wr = 0; enable = 1; tx_count = 3; step();
    cfg_wr = 1; tx_sel_in = 2'b11; step();
    cfg_wr = 0; step();
    check("R7", "tx_req after rejected write", tx_req, 0);
    // R10: overflow with ignore clear halts
    rx_count = 8; rx_word_valid = 1; step();
    rx_word_valid = 0; step();
    check("R10", "halt after overflow", halt_req, 1);
    enable = 0; step();
    check("R10", "halt cleared on disable", halt_req, 0);
    ovf_clear = 1; step(); ovf_clear = 0;
    check("R9", "flag cleared", ovf_flag, 0);
    for (int ph = 0; ph < 2; ph++) begin
      fifo_depth = (ph == 0) ? 4'd8 : 4'd5;
      for (int i = 0; i < 3000; i++) begin
        enable        = ($urandom % 10) != 0;
        cfg_wr        = ($urandom % 6) == 0;
        tx_sel_in     = 2'($urandom);
        rx_sel_in     = 2'($urandom);
        ovf_ign_in    = 1'($urandom);
        tx_count      = CW'($urandom % (fifo_depth + 1));
        rx_count      = CW'($urandom % (fifo_depth + 1));
        shift_busy    = 1'($urandom);
        rx_word_valid = 1'($urandom);
        ovf_clear     = ($urandom % 5) == 0;
        step();
      end
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog: run got %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule